// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Driver

This block turns a serial bit stream into a wide parallel word. Bits enter a chain of storage stages, one stage per shift event. A holding bank captures the chain's contents on command. A gating stage either presents the held word on the parallel outputs or drives every output low. The last stage is also brought out as a serial output, so several blocks can be chained. Each one then passes its overflow bits on to the next.

Everything runs on one system clock. A one-cycle shift strobe marks each shift event, in place of a separate shift clock. The holding bank behaves as a level-controlled latch that is sampled by the system clock: on every clock edge at which the capture control is high, it copies the chain. While that control is low, it keeps its value. Shifting continues no matter what the capture and gating controls are doing. This lets a new word stream in while the previous word stays on the outputs.

Top module: `ser_par_latch_drv`

## Requirements
- R1: On a clock edge with `rst_n` low, every stage and every holding bit becomes 0. After reset, `ser_out` is 0, and `par_out` is all zeros even with `out_en` high.
- R2: On a clock edge with `shift_stb` high, stage 1 takes `ser_in` and each stage k (k > 1) takes the old value of stage k-1. The result is visible after that edge.
- R3: `ser_out` always equals the last stage (stage `NUM_STAGES`). When two blocks are chained, 2·`NUM_STAGES` shifted bits fill both: with bit 0 shifted first, the first block's stage k holds bit 2N-k and the second block's stage k holds bit N-k.
- R4: On a clock edge with `shift_stb` low, the stages and `ser_out` keep their values, whatever `ser_in` is.
- R5: Shifting is unaffected by `latch_en` and `out_en`. The chain advances identically under any setting of those two inputs.
- R6: On each clock edge with `latch_en` high, the holding bank takes the stage contents present just before that edge. A value shifted in on the same edge therefore reaches the bank one edge later. On edges with `latch_en` low, the bank keeps its value.
- R7: While `out_en` is low, all of `par_out` is 0, whatever the holding bank contains.
- R8: While `out_en` is high, `par_out[k-1]` equals holding bit k, which comes from stage k. `par_out[0]` is the first stage.
- R9: The strobe may be high on every clock cycle, giving one shift per clock with no idle cycles. This is ample for an 8 MHz shift rate at any system clock of 8 MHz or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_stb | input | 1 | One-cycle shift event strobe |
| ser_in | input | 1 | Serial data into stage 1 |
| latch_en | input | 1 | Holding bank follows the chain while high |
| out_en | input | 1 | High shows held data, low forces outputs low |
| par_out | output | NUM_STAGES | Gated parallel outputs, bit 0 = stage 1 |
| ser_out | output | 1 | Last stage, for chaining |

## Verification
The timing of each result is as follows:
- A strobe changes the stages and `ser_out` one edge later.
- A capture with `latch_en` high changes the holding bank one edge later, so a bit shifted in with `latch_en` held high reaches `par_out` two edges after its strobe.
- `out_en` acts on `par_out` combinationally, within the same cycle.

The bench drives inputs on the falling edge. It updates its reference model using the values present at the rising edge. It compares all outputs 2 ns after that edge, when every registered result of that edge is settled. Two chained instances are checked on every cycle, under both directed patterns and seeded random controls.

// File: rtl/ser_par_pkg.sv
// Package: shared constants for the serial-to-parallel driver.
// Assumes: consumers take NUM_STAGES from here as their default.
package ser_par_pkg;
    localparam int unsigned SP_STAGES_DEFAULT = 32;

    // Gate a held word with the output enable.
    function automatic logic [SP_STAGES_DEFAULT-1:0] sp_blank(
        input logic [SP_STAGES_DEFAULT-1:0] word,
        input logic                         en
    );
        return en ? word : '0;
    endfunction
endpackage

// File: rtl/sp_shift_chain.sv
// Module: sp_shift_chain
// Serial-in, parallel-out chain. Stage 1 is bit 0 and the last stage is
// the top bit. It advances only on cycles with shift_stb high.
// Assumes: shift_stb is a single-cycle event in the clk domain.
module sp_shift_chain #(
    parameter int unsigned NUM_STAGES = ser_par_pkg::SP_STAGES_DEFAULT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_stb,
    input  logic                  ser_in,
    output logic [NUM_STAGES-1:0] stage_q,
    output logic                  last_q
);
    localparam int unsigned LAST = NUM_STAGES - 1;

    // Advance the chain by one stage per strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else if (shift_stb)
            stage_q <= {stage_q[LAST-1:0], ser_in};
    end

    // Serial output tracks the last stage directly.
    always_comb last_q = stage_q[LAST];

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_stb |=> $stable(stage_q));                            // R4
    AST_ENTRY_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |=> stage_q[0] == $past(ser_in));                  // R2
    AST_CARRY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |=> last_q == $past(stage_q[LAST-1]));             // R3
endmodule

// File: rtl/sp_latch_bank.sv
// Module: sp_latch_bank
// Holding bank. It copies the chain on every clk edge with latch_en high
// and holds its value otherwise.
// Assumes: the copy uses the chain value from before the same edge.
module sp_latch_bank #(
    parameter int unsigned NUM_STAGES = ser_par_pkg::SP_STAGES_DEFAULT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  latch_en,
    input  logic [NUM_STAGES-1:0] stage_in,
    output logic [NUM_STAGES-1:0] hold_q
);
    // Follow the chain while enabled, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (latch_en)
            hold_q <= stage_in;
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> $stable(hold_q));                              // R6
    AST_LATCH_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |=> hold_q == $past(stage_in));                     // R6
endmodule

// File: rtl/sp_out_gate.sv
// Module: sp_out_gate
// Per-bit output gating. Each output shows its held bit while out_en is
// high and is driven low otherwise.
// Assumes: purely combinational, no tri-state.
module sp_out_gate #(
    parameter int unsigned NUM_STAGES = ser_par_pkg::SP_STAGES_DEFAULT
) (
    input  logic                  out_en,
    input  logic [NUM_STAGES-1:0] hold_in,
    output logic [NUM_STAGES-1:0] par_out
);
    // One AND gate per output bit.
    for (genvar gi = 0; gi < NUM_STAGES; gi++) begin : g_bit
        always_comb par_out[gi] = out_en & hold_in[gi];
    end
endmodule

// File: rtl/ser_par_latch_drv.sv
// Module: ser_par_latch_drv (top)
// Shift chain -> holding bank -> output gate, with the last stage brought
// out for chaining.
// Assumes: single clock domain, synchronous active-low reset.
module ser_par_latch_drv #(
    parameter int unsigned NUM_STAGES = ser_par_pkg::SP_STAGES_DEFAULT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_stb,
    input  logic                  ser_in,
    input  logic                  latch_en,
    input  logic                  out_en,
    output logic [NUM_STAGES-1:0] par_out,
    output logic                  ser_out
);
    logic [NUM_STAGES-1:0] stage_w;
    logic [NUM_STAGES-1:0] hold_w;

    sp_shift_chain #(.NUM_STAGES(NUM_STAGES)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_stb (shift_stb),
        .ser_in    (ser_in),
        .stage_q   (stage_w),
        .last_q    (ser_out)
    );

    sp_latch_bank #(.NUM_STAGES(NUM_STAGES)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_en (latch_en),
        .stage_in (stage_w),
        .hold_q   (hold_w)
    );

    sp_out_gate #(.NUM_STAGES(NUM_STAGES)) u_gate (
        .out_en  (out_en),
        .hold_in (hold_w),
        .par_out (par_out)
    );

    AST_BLANK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> par_out == '0);                                  // R7
    AST_SHOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && out_en) |=> (!out_en || par_out == $past(stage_w))); // R8
endmodule

// File: tb/test_ser_par_latch_drv.sv
module test_ser_par_latch_drv;
    localparam int N = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_stb = 1'b0, ser_in = 1'b0, latch_en = 1'b0, out_en = 1'b1;
    logic [N-1:0] par_a, par_b;
    logic ser_a, ser_b;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [N-1:0] sr_a = '0, sr_b = '0, lat_a = '0, lat_b = '0;

    always #5 clk = ~clk;

    ser_par_latch_drv #(.NUM_STAGES(N)) i_ser_par_latch_drv (
        .clk(clk), .rst_n(rst_n), .shift_stb(shift_stb), .ser_in(ser_in),
        .latch_en(latch_en), .out_en(out_en), .par_out(par_a), .ser_out(ser_a));

    ser_par_latch_drv #(.NUM_STAGES(N)) i_ser_par_latch_drv_tail (
        .clk(clk), .rst_n(rst_n), .shift_stb(shift_stb), .ser_in(ser_a),
        .latch_en(latch_en), .out_en(out_en), .par_out(par_b), .ser_out(ser_b));

    function automatic logic [N-1:0] gated(input logic [N-1:0] w, input logic en);
        return en ? w : '0;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive at falling edge, update the model at the rising edge.
    task automatic cyc(input logic stb, input logic din, input logic le, input logic oe);
        @(negedge clk);
        shift_stb = stb; ser_in = din; latch_en = le; out_en = oe;
        @(posedge clk);
        if (le) begin lat_a = sr_a; lat_b = sr_b; end
        if (stb) begin
            sr_b = {sr_b[N-2:0], sr_a[N-1]};
            sr_a = {sr_a[N-2:0], din};
        end
        #2;
    endtask

    task automatic chk_all(input string req);
        chk({req, " par_a"}, 64'(par_a), 64'(gated(lat_a, out_en)));
        chk({req, " par_b"}, 64'(par_b), 64'(gated(lat_b, out_en)));
        chk({req, " ser_a"}, 64'(ser_a), 64'(sr_a[N-1]));
        chk({req, " ser_b"}, 64'(ser_b), 64'(sr_b[N-1]));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] pat;
        logic [N-1:0] snap;
        int unsigned seed;
        seed = $urandom(32'd4242);
        pat = 64'hA5C3_0F96_1E7B_D248;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state, outputs low even with out_en high
        chk("R1 par_a", 64'(par_a), 64'd0);
        chk("R1 par_b", 64'(par_b), 64'd0);
        chk("R1 ser", {62'd0, ser_a, ser_b}, 64'd0);

        // R9 R2 R3: back-to-back strobes fill both devices, no latch yet
        for (int j = 0; j < 64; j++) cyc(1'b1, pat[j], 1'b0, 1'b1);
        chk("R6 hold while filling", 64'(par_a), 64'd0);
        cyc(1'b0, 1'b0, 1'b1, 1'b1);
        begin
            logic [N-1:0] ea, eb;
            for (int k = 1; k <= N; k++) begin
                ea[k-1] = pat[64-k];
                eb[k-1] = pat[32-k];
            end
            chk("R3 R8 chain device A", 64'(par_a), 64'(ea));
            chk("R3 R8 chain device B", 64'(par_b), 64'(eb));
            chk("R3 ser_out A", 64'(ser_a), 64'(pat[32]));
            chk("R3 ser_out B", 64'(ser_b), 64'(pat[0]));
        end

        // R4: no strobe, toggling ser_in leaves stages unchanged
        for (int j = 0; j < 6; j++) begin
            cyc(1'b0, j[0], 1'b0, 1'b1);
            chk_all("R4");
        end
        cyc(1'b0, 1'b1, 1'b1, 1'b1);
        chk_all("R4 stages unchanged");

        // R6: strobe with latch_en high on the same edge captures old value
        snap = par_a;
        cyc(1'b1, 1'b1, 1'b1, 1'b1);
        chk("R6 same-edge capture old", 64'(par_a), 64'(snap));
        cyc(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R6 next-edge capture new", 64'(par_a), 64'({snap[N-2:0], 1'b1}));

        // R7: out_en low forces zero
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 blank A", 64'(par_a), 64'd0);
        chk("R7 blank B", 64'(par_b), 64'd0);

        // R5: shifting continues with latch_en low, out_en low
        for (int j = 0; j < 5; j++) begin
            cyc(1'b1, ~j[0], 1'b0, 1'b0);
            chk_all("R5");
        end
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        chk_all("R6 held after shifts");

        // Random mix against the model
        for (int j = 0; j < 400; j++) begin
            cyc(1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) != 0);
            chk_all("R2 R5 R6 R7 R8 random");
        end
        finish_run();
    end
endmodule